// File: doc/BRIEF.md
# Banked Serial Pattern Register Store

This block keeps four transmit waveform patterns for a pulser playback engine. Each pattern is a pair of equal-length words. The high-side word (P) drives the output switch toward the positive rail, and the low-side word (N) drives it toward the negative rail. Software or an upstream controller fills one pattern at a time over a simple serial link. The link has a serial clock, serial data in, an active-low select and a registered serial data out, and devices can be chained through that output. A two-bit bank address picks the pattern that receives the stream. A width input picks 16-bit or 32-bit words.

Inside the addressed bank, the P and N words form one shift chain. Serial data enters at the top bit of P. It ripples down through P and then through N, and it leaves from the bottom of N. Words are sent least significant bit first, so a stream holding the N word followed by the P word leaves every bit in its natural position. A parallel read port returns both words of any bank at once. The playback engine uses it without disturbing the serial side.

Top module: `pattern_bank_store`

## Requirements
- R1: A synchronous reset (srst high at a rising sclk edge) clears every word of all four banks to zero and drives sdo to 0.
- R2: A bank shifts only on a rising sclk edge while sel_n is low. While sel_n is high, all bank contents and sdo hold their values, whatever sdi, bank_addr and sclk do.
- R3: bank_addr value 0, 1, 2 or 3 selects pattern bank 0, 1, 2 or 3. Only the addressed bank shifts, and the other three keep their words.
- R4: With width_wide = 1 the chain is 64 bits long. sdi enters P bit 31, P bit 0 feeds N bit 31, and N bit 0 is the chain end. After 64 shifts of stream bits b0..b63, N bit k holds bk and P bit k holds b(32+k), for k = 0..31.
- R5: With width_wide = 0 the chain is 32 bits long. sdi enters P bit 15, P bit 0 feeds N bit 15, and N bit 0 is the chain end. After 32 shifts of stream bits b0..b31, N bit k holds bk and P bit k holds b(16+k), for k = 0..15.
- R6: While width_wide = 0, bits 31..16 of rd_p and rd_n read as zero. A shift in this mode also clears those upper bits in the shifted bank.
- R7: After each shifting edge, sdo equals the new bit 0 of the addressed bank's N word. At the end of a full chain length of shifts, the first bit sent is on sdo. After each further shift, sdo gives the next bit sent, in order.
- R8: rd_p and rd_n show the P and N words of the bank numbered by rd_bank in the same cycle, masked as R6 requires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; all state changes on its rising edge |
| srst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Serial select, active low; enables shifting |
| sdi | input | 1 | Serial data in, least significant bit first |
| width_wide | input | 1 | Word width: 0 = 16 bits, 1 = 32 bits |
| bank_addr | input | 2 | Bank that receives the serial stream |
| sdo | output | 1 | Registered chain end of the addressed bank, for chaining |
| rd_bank | input | 2 | Bank shown on the read port |
| rd_p | output | 32 | High-side word of the bank being read |
| rd_n | output | 32 | Low-side word of the bank being read |

## Verification
The read port is combinational, so rd_p and rd_n are compared one time step after rd_bank is set, with no clock edge in between. Bank words and sdo each pass through one register stage. Their new values are due just after the same rising sclk edge that takes in the sdi bit, so the bench drives sdi, sel_n and the addresses on falling edges and samples shortly after each rising edge. The expected sdo for every shift comes from concatenating the old chain with the stream, which also covers the daisy-chain overrun past the chain length.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

   typedef enum logic {
      WIDTH_NARROW = 1'b0,
      WIDTH_WIDE   = 1'b1
   } width_sel_e;

   // Mask that keeps the low `used` bits of a `total`-bit word.
   function automatic logic [63:0] low_mask(input int unsigned used);
      logic [63:0] m;
      m = '0;
      for (int i = 0; i < 64; i++) begin
         if (i < used) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/pbs_bank_decode.sv
module pbs_bank_decode #(
   parameter int NUM_BANKS = 4,
   parameter int ADDR_W    = 2
) (
   input  logic                 sel_n,
   input  logic [ADDR_W-1:0]    addr,
   output logic [NUM_BANKS-1:0] bank_en
);

   initial begin
      assert ((1 << ADDR_W) >= NUM_BANKS)
         else $error("pbs_bank_decode: address too narrow for bank count");
   end

   for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_en
      assign bank_en[gi] = !sel_n && (addr == ADDR_W'(gi));
   end

endmodule

// File: rtl/pbs_chain_bank.sv
module pbs_chain_bank #(
   parameter int WORD_W    = 32,
   parameter int NARROW_W  = 16,
   parameter bit NARROW_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              shift_en,
   input  logic              wide,
   input  logic              sdi,
   output logic [WORD_W-1:0] p_q,
   output logic [WORD_W-1:0] n_q,
   output logic              tail_next
);

   logic [WORD_W-1:0] p_nxt;
   logic [WORD_W-1:0] n_nxt;

   initial begin
      assert (WORD_W >= 2) else $error("pbs_chain_bank: WORD_W must be at least 2");
      assert (!NARROW_EN || (NARROW_W >= 2 && NARROW_W < WORD_W))
         else $error("pbs_chain_bank: NARROW_W must lie in 2..WORD_W-1");
   end

   if (NARROW_EN) begin : g_dual
      always_comb begin
         if (wide) begin
            p_nxt = {sdi, p_q[WORD_W-1:1]};
            n_nxt = {p_q[0], n_q[WORD_W-1:1]};
         end else begin
            p_nxt = '0;
            n_nxt = '0;
            p_nxt[NARROW_W-1:0] = {sdi, p_q[NARROW_W-1:1]};
            n_nxt[NARROW_W-1:0] = {p_q[0], n_q[NARROW_W-1:1]};
         end
      end
   end else begin : g_wide_only
      logic unused_wide;
      assign unused_wide = wide;
      always_comb begin
         p_nxt = {sdi, p_q[WORD_W-1:1]};
         n_nxt = {p_q[0], n_q[WORD_W-1:1]};
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         p_q <= '0;
         n_q <= '0;
      end else if (shift_en) begin
         p_q <= p_nxt;
         n_q <= n_nxt;
      end
   end

   // Bit that becomes the chain end on the next shift (same in both widths).
   assign tail_next = n_q[1];

   a_r1_clear: assert property (@(posedge clk)
      rst |=> (p_q == '0) && (n_q == '0));

   a_r2_hold: assert property (@(posedge clk) disable iff (rst)
      !shift_en |=> $stable(p_q) && $stable(n_q));

   a_r4_entry: assert property (@(posedge clk) disable iff (rst)
      (shift_en && wide) |=> p_q[WORD_W-1] == $past(sdi));

   a_r4_link: assert property (@(posedge clk) disable iff (rst)
      (shift_en && wide) |=> n_q[WORD_W-1] == $past(p_q[0]));

   if (NARROW_EN) begin : g_narrow_chk
      a_r5_entry: assert property (@(posedge clk) disable iff (rst)
         (shift_en && !wide) |=> p_q[NARROW_W-1] == $past(sdi));

      a_r5_link: assert property (@(posedge clk) disable iff (rst)
         (shift_en && !wide) |=> n_q[NARROW_W-1] == $past(p_q[0]));

      a_r6_upper_zero: assert property (@(posedge clk) disable iff (rst)
         (shift_en && !wide) |=> (p_q[WORD_W-1:NARROW_W] == '0) &&
                                 (n_q[WORD_W-1:NARROW_W] == '0));
   end

endmodule

// File: rtl/pbs_sdo_stage.sv
module pbs_sdo_stage #(
   parameter int NUM_BANKS = 4,
   parameter int ADDR_W    = 2
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 shift_any,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [NUM_BANKS-1:0] tails,
   output logic                 sdo
);

   logic tail_sel;

   always_comb begin
      tail_sel = 1'b0;
      for (int i = 0; i < NUM_BANKS; i++) begin
         if (addr == ADDR_W'(i)) tail_sel = tails[i];
      end
   end

   always_ff @(posedge clk) begin
      if (rst)            sdo <= 1'b0;
      else if (shift_any) sdo <= tail_sel;
   end

   a_r1_sdo_clear: assert property (@(posedge clk) rst |=> !sdo);

   a_r2_sdo_hold: assert property (@(posedge clk) disable iff (rst)
      !shift_any |=> $stable(sdo));

endmodule

// File: rtl/pattern_bank_store.sv
module pattern_bank_store #(
   parameter int NUM_BANKS  = 4,
   parameter int WORD_W     = 32,
   parameter int NARROW_W   = 16,
   parameter bit NARROW_EN  = 1'b1,
   localparam int ADDR_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic              sclk,
   input  logic              srst,
   input  logic              sel_n,
   input  logic              sdi,
   input  logic              width_wide,
   input  logic [ADDR_W-1:0] bank_addr,
   output logic              sdo,
   input  logic [ADDR_W-1:0] rd_bank,
   output logic [WORD_W-1:0] rd_p,
   output logic [WORD_W-1:0] rd_n
);
   import pbs_pkg::*;

   localparam logic [63:0] NARROW_MASK64 = low_mask(NARROW_W);
   localparam logic [WORD_W-1:0] NARROW_MASK = NARROW_MASK64[WORD_W-1:0];

   width_sel_e                          mode;
   logic [NUM_BANKS-1:0]                bank_en;
   logic [NUM_BANKS-1:0]                tails;
   logic [NUM_BANKS-1:0][WORD_W-1:0]    p_all;
   logic [NUM_BANKS-1:0][WORD_W-1:0]    n_all;
   logic [WORD_W-1:0]                   p_sel;
   logic [WORD_W-1:0]                   n_sel;

   initial begin
      assert (NUM_BANKS >= 1) else $error("pattern_bank_store: need at least one bank");
      assert (WORD_W <= 64) else $error("pattern_bank_store: WORD_W above 64");
   end

   assign mode = width_sel_e'(width_wide);

   pbs_bank_decode #(
      .NUM_BANKS (NUM_BANKS),
      .ADDR_W    (ADDR_W)
   ) i_decode (
      .sel_n   (sel_n),
      .addr    (bank_addr),
      .bank_en (bank_en)
   );

   for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
      pbs_chain_bank #(
         .WORD_W    (WORD_W),
         .NARROW_W  (NARROW_W),
         .NARROW_EN (NARROW_EN)
      ) i_bank (
         .clk       (sclk),
         .rst       (srst),
         .shift_en  (bank_en[gb]),
         .wide      (mode == WIDTH_WIDE),
         .sdi       (sdi),
         .p_q       (p_all[gb]),
         .n_q       (n_all[gb]),
         .tail_next (tails[gb])
      );
   end

   pbs_sdo_stage #(
      .NUM_BANKS (NUM_BANKS),
      .ADDR_W    (ADDR_W)
   ) i_sdo (
      .clk       (sclk),
      .rst       (srst),
      .shift_any (!sel_n),
      .addr      (bank_addr),
      .tails     (tails),
      .sdo       (sdo)
   );

   always_comb begin
      p_sel = '0;
      n_sel = '0;
      for (int i = 0; i < NUM_BANKS; i++) begin
         if (rd_bank == ADDR_W'(i)) begin
            p_sel = p_all[i];
            n_sel = n_all[i];
         end
      end
   end

   if (NARROW_EN) begin : g_rd_mask
      assign rd_p = (mode == WIDTH_WIDE) ? p_sel : (p_sel & NARROW_MASK);
      assign rd_n = (mode == WIDTH_WIDE) ? n_sel : (n_sel & NARROW_MASK);
   end else begin : g_rd_plain
      assign rd_p = p_sel;
      assign rd_n = n_sel;
   end

   a_r3_single_bank: assert property (@(posedge sclk) disable iff (srst)
      $onehot0(bank_en));

   a_r2_idle_no_bank: assert property (@(posedge sclk) disable iff (srst)
      sel_n |-> (bank_en == '0));

   a_r3_addressed_bank: assert property (@(posedge sclk) disable iff (srst)
      !sel_n |-> $countones(bank_en) == 1);

   if (NARROW_EN) begin : g_rd_chk
      a_r6_read_zero: assert property (@(posedge sclk) disable iff (srst)
         !width_wide |-> (rd_p[WORD_W-1:NARROW_W] == '0) &&
                         (rd_n[WORD_W-1:NARROW_W] == '0));
   end

endmodule

// File: tb/test_pattern_bank_store.sv
`timescale 1ns/1ps
module test_pattern_bank_store;

   localparam int HALF = 10;

   logic        sclk = 1'b0;
   logic        srst;
   logic        sel_n;
   logic        sdi;
   logic        width_wide;
   logic [1:0]  bank_addr;
   logic        sdo;
   logic [1:0]  rd_bank;
   logic [31:0] rd_p;
   logic [31:0] rd_n;

   int checks = 0;
   int errors = 0;

   logic [31:0] mp [4];
   logic [31:0] mn [4];

   always #HALF sclk = ~sclk;

   pattern_bank_store i_pattern_bank_store (
      .sclk       (sclk),
      .srst       (srst),
      .sel_n      (sel_n),
      .sdi        (sdi),
      .width_wide (width_wide),
      .bank_addr  (bank_addr),
      .sdo        (sdo),
      .rd_bank    (rd_bank),
      .rd_p       (rd_p),
      .rd_n       (rd_n)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Old chain in position order: position 0 is N bit 0.
   function automatic logic [63:0] chain_of(input int b, input bit wide);
      if (wide) return {mp[b], mn[b]};
      return {32'h0, mp[b][15:0], mn[b][15:0]};
   endfunction

   task automatic check_all_banks(input string req);
      for (int b = 0; b < 4; b++) begin
         logic [31:0] ep, en;
         rd_bank = 2'(b);
         #1;
         ep = width_wide ? mp[b] : {16'h0, mp[b][15:0]};
         en = width_wide ? mn[b] : {16'h0, mn[b][15:0]};
         chk({req, " read P"}, {32'h0, rd_p}, {32'h0, ep});
         chk({req, " read N"}, {32'h0, rd_n}, {32'h0, en});
      end
   endtask

   // Shift m stream bits into bank b; checks sdo after every edge (R7).
   task automatic load(input int b, input bit wide, input logic [127:0] s, input int m);
      int L;
      logic [63:0]  old;
      logic [191:0] seq;
      L = wide ? 64 : 32;
      @(negedge sclk);
      width_wide = wide;
      old = chain_of(b, wide);
      seq = '0;
      for (int k = 0; k < 192; k++) begin
         if (k < L) seq[k] = old[k];
         else if (k - L < 128) seq[k] = s[k - L];
      end
      bank_addr = 2'(b);
      sel_n = 1'b0;
      for (int j = 1; j <= m; j++) begin
         sdi = s[j-1];
         @(posedge sclk);
         #2;
         chk("R7 sdo after shift", {63'h0, sdo}, {63'h0, seq[j]});
         @(negedge sclk);
      end
      sel_n = 1'b1;
      if (!wide) begin
         mp[b][31:16] = '0;
         mn[b][31:16] = '0;
      end
      for (int k = 0; k < L; k++) begin
         if (wide) begin
            if (k < 32) mn[b][k] = seq[m+k];
            else        mp[b][k-32] = seq[m+k];
         end else begin
            if (k < 16) mn[b][k] = seq[m+k];
            else        mp[b][k-16] = seq[m+k];
         end
      end
   endtask

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(200000 * 2 * HALF);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      srst = 1'b1; sel_n = 1'b1; sdi = 1'b0; width_wide = 1'b1;
      bank_addr = 2'd0; rd_bank = 2'd0;
      for (int b = 0; b < 4; b++) begin mp[b] = '0; mn[b] = '0; end
      repeat (3) @(negedge sclk);
      srst = 1'b0;
      #1;
      // R1: reset state
      chk("R1 sdo after reset", {63'h0, sdo}, 64'h0);
      check_all_banks("R1 reset");

      // R3, R4, R8: wide loads into every bank, all banks read back
      for (int b = 0; b < 4; b++) begin
         logic [127:0] s;
         s = {64'h0, 32'hC3A5_0000 + 32'(b * 32'h0102_4081), 32'h1357_9BDF ^ 32'(b * 32'h1111_0F0F)};
         load(b, 1'b1, s, 64);
         check_all_banks("R3 R4 R8 wide load");
      end

      // R5, R6: narrow loads, upper halves read as zero
      for (int b = 0; b < 4; b++) begin
         logic [127:0] s;
         s = {96'h0, 16'h8E31 ^ 16'(b * 16'h2345), 16'h7A1C + 16'(b * 16'h0F11)};
         load(b, 1'b0, s, 32);
         check_all_banks("R5 R6 narrow load");
      end

      // R4 again over narrow-shifted contents (upper bits cleared), wide view
      @(negedge sclk);
      width_wide = 1'b1;
      check_all_banks("R6 cleared upper bits wide view");

      // R2: select high, clocks and sdi toggling, nothing changes
      begin
         logic keep;
         keep = sdo;
         for (int j = 0; j < 12; j++) begin
            @(negedge sclk);
            sdi = j[0];
            bank_addr = 2'(j);
            width_wide = j[1];
            @(posedge sclk);
            #2;
            chk("R2 sdo holds while deselected", {63'h0, sdo}, {63'h0, keep});
         end
         @(negedge sclk);
         width_wide = 1'b0;
         check_all_banks("R2 banks hold while deselected narrow");
         width_wide = 1'b1;
         check_all_banks("R2 banks hold while deselected wide");
      end

      // R7: daisy-chain overrun past the chain length, both widths
      load(2, 1'b1, {28'h0, 100'hA_F00D_CAFE_1234_5678_9ABC_DEF0}, 70);
      check_all_banks("R7 wide overrun");
      load(1, 1'b0, {88'h0, 40'h5_B6D_E3F2_A1}, 37);
      check_all_banks("R7 narrow overrun");

      // R1: reset clears loaded contents
      @(negedge sclk);
      width_wide = 1'b1;
      load(3, 1'b1, {64'h0, 64'hFFFF_0000_FFFF_FFFF}, 64);
      @(negedge sclk);
      srst = 1'b1;
      @(negedge sclk);
      srst = 1'b0;
      for (int b = 0; b < 4; b++) begin mp[b] = '0; mn[b] = '0; end
      #1;
      chk("R1 sdo after mid-run reset", {63'h0, sdo}, 64'h0);
      check_all_banks("R1 mid-run reset");

      finish_run();
   end

endmodule